// File: doc/BRIEF.md
# Hint-Assisted Branch Predictor

This block predicts the next program counter for a core's fetch stage. It has a small native predictor of its own: a bimodal table of 2-bit direction counters, each with a stored target. On top of that it accepts a stream of branch hints from a helper core that runs ahead on the same program. That helper core may be faulty. Each hint names a branch address, a target, a branch kind and an age tag, which is the helper's position in program order counted in committed instructions. Hints wait in a small in-order buffer. The hint at the head is offered for prediction only when its age falls inside a window ahead of the local committed-instruction count. A head hint whose age is already behind that count is thrown away.

For each branch, a per-index 2-bit selection counter chooses between the head hint and the native prediction. The hint is offered only when the head's address matches the lookup address. When a branch resolves, both predictions are judged against the real next address, and the selection counter and the bimodal entry are trained. A global monitor counter rises when the hint alone was wrong and falls when the hint alone was right. While the monitor is above a programmable threshold, hints are switched off and only native predictions come out. A resynchronisation pulse from the core empties the hint buffer.

The hint input is a valid/ready stream. `hint_ready` is held high so that the helper core is never stalled. The block applies its own back-pressure policy: a hint that arrives while the buffer is full is discarded and counted. Lookup, resolve and control pins are plain signals with no handshake.

Top module: `hbp_hint_predictor`

## Requirements
- R1: `hint_ready` is always 1. A hint with `hint_valid` high is accepted when the buffer held fewer than QDEPTH (default 4) entries before that cycle. Otherwise the hint is discarded and `hint_drops` rises by one. This also holds in a cycle where a resolve removes the head.
- R2: The head hint is usable only if its age is at most `commit_cnt + release_win`, with the sum computed without wrap. A head hint that is not yet released has no effect on predictions.
- R3: A head hint whose age is less than `commit_cnt` is stale. It is never used for prediction, and it is removed at the next clock edge.
- R4: `pred_next` and `pred_from_hint` are combinational in `pred_pc`. The hint's target is chosen when all of the following hold: hints are enabled, the head is usable, the head's address equals `pred_pc`, and either the hint kind is not conditional or the selection counter at index `pred_pc[5:2]` is 2 or more. Hint kinds are 0 conditional, 1 jump, 2 call, 3 return.
- R5: The native prediction is the stored target when the bimodal counter at `pc[5:2]` is 2 or more, and `pc+4` otherwise. Counters reset to 1 and stored targets to 0. Each resolve is taken when `res_next != res_pc+4`. A taken resolve raises the counter, saturating at 3, and stores the target. A not-taken resolve lowers the counter, saturating at 0.
- R6: Selection counters reset to 2. When a resolve hits a usable head with a matching address, the counter rises by one (saturating at 3) if only the hint was right, and falls by one (saturating at 0) if only the native prediction was right.
- R7: The monitor counter starts at 0. On a resolve that hits the head, it rises by one when the hint is wrong and the native prediction is right, and falls by one when the hint is right and the native prediction is wrong. It saturates at 0 and at its maximum. `hints_enabled` is 0 exactly while the monitor exceeds `mon_threshold`, and while it is 0 only native predictions are produced.
- R8: `resync` empties the buffer at the next edge. A hint arriving in the same cycle is discarded and is not counted in `hint_drops`.
- R9: A resolve that hits the usable head with a matching address removes that hint from the buffer.
- R10: After reset the buffer is empty, `hint_drops` is 0, `hints_enabled` is 1, and a lookup of any PC returns `pc+4` with `pred_from_hint` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hint_valid | input | 1 | Hint stream valid |
| hint_ready | output | 1 | Hint stream ready (constant 1) |
| hint_pc | input | 32 | Branch address carried by the hint |
| hint_target | input | 32 | Next address carried by the hint |
| hint_type | input | 2 | Hint kind: 0 conditional, 1 jump, 2 call, 3 return |
| hint_age | input | 16 | Program-order age tag of the hint |
| commit_cnt | input | 16 | Local committed-instruction count |
| release_win | input | 16 | Release window added to the committed count |
| mon_threshold | input | 4 | Monitor level above which hints are disabled |
| resync | input | 1 | Flush all buffered hints |
| pred_pc | input | 32 | Lookup address |
| pred_next | output | 32 | Predicted next address |
| pred_from_hint | output | 1 | Prediction was taken from a hint |
| res_valid | input | 1 | Branch resolve strobe |
| res_pc | input | 32 | Resolved branch address |
| res_next | input | 32 | Actual next address |
| hints_enabled | output | 1 | Hint use currently allowed |
| hint_drops | output | 8 | Count of hints discarded at a full buffer |

## Verification
Two pairs of functions can act in the same cycle. In the first pair, a resolve frees the head slot in the very cycle that a hint arrives at a full buffer. The bench provokes this and expects the hint to be dropped and counted; a later hint must then be accepted and must reach the head in order. In the second pair, `resync` and an arriving hint fall together. The bench expects the buffer to be empty afterwards, with no drop counted, and judges this through lookups of both the flushed address and the arriving address, each of which must return the native prediction.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  localparam int XLEN  = 32;
  localparam int AGE_W = 16;

  typedef enum logic [1:0] {
    HK_COND = 2'd0,
    HK_JUMP = 2'd1,
    HK_CALL = 2'd2,
    HK_RET  = 2'd3
  } hint_kind_e;

  typedef struct packed {
    logic [XLEN-1:0]  pc;
    logic [XLEN-1:0]  target;
    logic [1:0]       kind;
    logic [AGE_W-1:0] age;
  } hint_t;
endpackage

// File: rtl/hbp_hint_queue.sv
module hbp_hint_queue
  import hbp_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DROP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  hint_t               in_hint,
  input  logic                flush,
  input  logic                consume,
  input  logic [AGE_W-1:0]    commit_cnt,
  input  logic [AGE_W-1:0]    release_win,
  output hint_t               head,
  output logic                head_live,
  output logic [DROP_W-1:0]   drops
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  hint_t           mem_q [DEPTH];
  logic [PW-1:0]   rd_q, wr_q;
  logic [CW-1:0]   cnt_q;
  logic            full, head_valid, stale, released, accept, pop;

  assign full       = (cnt_q == CW'(DEPTH));
  assign head_valid = (cnt_q != '0);
  assign head       = mem_q[rd_q];
  assign stale      = head_valid && (head.age < commit_cnt);
  assign released   = {1'b0, head.age} <= ({1'b0, commit_cnt} + {1'b0, release_win});
  assign head_live  = head_valid && !stale && released;
  assign accept     = in_valid && !full && !flush;
  assign pop        = stale || (consume && head_live);

  always_ff @(posedge clk) begin
    if (accept) mem_q[wr_q] <= in_hint;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (accept) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)    rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(accept) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) drops <= '0;
    else if (in_valid && full && !flush) drops <= drops + 1'b1;
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_drop_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !flush) |=> drops == $past(drops) + 1'b1);
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt_q == '0);
  p_stale_leaves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stale && !accept && !flush) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/hbp_bimodal.sv
module hbp_bimodal
  import hbp_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] rd_pc,
  output logic [XLEN-1:0] rd_next,
  input  logic            upd_valid,
  input  logic [XLEN-1:0] upd_pc,
  input  logic [XLEN-1:0] upd_next,
  output logic [XLEN-1:0] upd_pred
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [1:0]      cnt_q [ENTRIES];
  logic [XLEN-1:0] tgt_q [ENTRIES];
  logic [IDX_W-1:0] rd_idx, up_idx;
  logic             taken;

  assign rd_idx   = rd_pc[IDX_W+1:2];
  assign up_idx   = upd_pc[IDX_W+1:2];
  assign rd_next  = cnt_q[rd_idx][1] ? tgt_q[rd_idx] : rd_pc + 32'd4;
  assign upd_pred = cnt_q[up_idx][1] ? tgt_q[up_idx] : upd_pc + 32'd4;
  assign taken    = (upd_next != upd_pc + 32'd4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        cnt_q[i] <= 2'd1;
        tgt_q[i] <= '0;
      end
    end else if (upd_valid) begin
      if (taken) begin
        tgt_q[up_idx] <= upd_next;
        if (cnt_q[up_idx] != 2'd3) cnt_q[up_idx] <= cnt_q[up_idx] + 2'd1;
      end else if (cnt_q[up_idx] != 2'd0) begin
        cnt_q[up_idx] <= cnt_q[up_idx] - 2'd1;
      end
    end
  end

  p_taken_learns_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && taken) |=> tgt_q[$past(up_idx)] == $past(upd_next));
endmodule

// File: rtl/hbp_chooser.sv
module hbp_chooser #(
  parameter int IDX_W = 4,
  parameter int MON_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             prefer_hint,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             hint_ok,
  input  logic             nat_ok,
  input  logic [MON_W-1:0] mon_threshold,
  output logic             hints_enabled
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [MON_W-1:0] MON_MAX = '1;

  logic [1:0]       sel_q [ENTRIES];
  logic [MON_W-1:0] mon_q;
  logic             hint_only, nat_only;

  assign hint_only     = upd_valid && hint_ok && !nat_ok;
  assign nat_only      = upd_valid && nat_ok && !hint_ok;
  assign prefer_hint   = sel_q[rd_idx][1];
  assign hints_enabled = !(mon_q > mon_threshold);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) sel_q[i] <= 2'd2;
    end else if (hint_only && sel_q[upd_idx] != 2'd3) begin
      sel_q[upd_idx] <= sel_q[upd_idx] + 2'd1;
    end else if (nat_only && sel_q[upd_idx] != 2'd0) begin
      sel_q[upd_idx] <= sel_q[upd_idx] - 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mon_q <= '0;
    else if (nat_only && mon_q != MON_MAX) mon_q <= mon_q + 1'b1;
    else if (hint_only && mon_q != '0) mon_q <= mon_q - 1'b1;
  end

  p_mon_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_q == '0 && !nat_only) |=> mon_q == '0);
  p_mon_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(mon_q));
endmodule

// File: rtl/hbp_hint_predictor.sv
module hbp_hint_predictor
  import hbp_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int IDX_W  = 4,
  parameter int MON_W  = 4,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hint_valid,
  output logic              hint_ready,
  input  logic [XLEN-1:0]   hint_pc,
  input  logic [XLEN-1:0]   hint_target,
  input  logic [1:0]        hint_type,
  input  logic [AGE_W-1:0]  hint_age,
  input  logic [AGE_W-1:0]  commit_cnt,
  input  logic [AGE_W-1:0]  release_win,
  input  logic [MON_W-1:0]  mon_threshold,
  input  logic              resync,
  input  logic [XLEN-1:0]   pred_pc,
  output logic [XLEN-1:0]   pred_next,
  output logic              pred_from_hint,
  input  logic              res_valid,
  input  logic [XLEN-1:0]   res_pc,
  input  logic [XLEN-1:0]   res_next,
  output logic              hints_enabled,
  output logic [DROP_W-1:0] hint_drops
);
  hint_t           in_h, head;
  logic            head_live, res_hit, prefer_hint, pred_match;
  logic [XLEN-1:0] nat_next, nat_at_res;

  assign hint_ready = 1'b1;
  assign in_h.pc     = hint_pc;
  assign in_h.target = hint_target;
  assign in_h.kind   = hint_type;
  assign in_h.age    = hint_age;

  hbp_hint_queue #(.DEPTH(QDEPTH), .DROP_W(DROP_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .in_valid(hint_valid), .in_hint(in_h),
    .flush(resync), .consume(res_hit), .commit_cnt(commit_cnt),
    .release_win(release_win), .head(head), .head_live(head_live),
    .drops(hint_drops)
  );

  hbp_bimodal #(.IDX_W(IDX_W)) u_native (
    .clk(clk), .rst_n(rst_n), .rd_pc(pred_pc), .rd_next(nat_next),
    .upd_valid(res_valid), .upd_pc(res_pc), .upd_next(res_next),
    .upd_pred(nat_at_res)
  );

  assign res_hit = res_valid && head_live && (head.pc == res_pc);

  hbp_chooser #(.IDX_W(IDX_W), .MON_W(MON_W)) u_choose (
    .clk(clk), .rst_n(rst_n), .rd_idx(pred_pc[IDX_W+1:2]),
    .prefer_hint(prefer_hint), .upd_valid(res_hit),
    .upd_idx(res_pc[IDX_W+1:2]), .hint_ok(head.target == res_next),
    .nat_ok(nat_at_res == res_next), .mon_threshold(mon_threshold),
    .hints_enabled(hints_enabled)
  );

  assign pred_match     = head_live && (head.pc == pred_pc);
  assign pred_from_hint = hints_enabled && pred_match &&
                          ((head.kind != HK_COND) || prefer_hint);
  assign pred_next      = pred_from_hint ? head.target : nat_next;

  p_disabled_native_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hints_enabled |-> (!pred_from_hint && pred_next == nat_next));
  p_ready_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hint_ready);
endmodule

// File: tb/hbp_hint_predictor_tb.sv
module hbp_hint_predictor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hint_valid = 1'b0;
  logic        hint_ready;
  logic [31:0] hint_pc = '0, hint_target = '0;
  logic [1:0]  hint_type = '0;
  logic [15:0] hint_age = '0, commit_cnt = '0, release_win = 16'd8;
  logic [3:0]  mon_threshold = 4'd2;
  logic        resync = 1'b0;
  logic [31:0] pred_pc = '0, pred_next;
  logic        pred_from_hint;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0, res_next = '0;
  logic        hints_enabled;
  logic [7:0]  hint_drops;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_next_q[$];
  logic        exp_flag_q[$];
  string       exp_tag_q[$];

  always #2 clk = ~clk;

  hbp_hint_predictor u_dut (
    .clk(clk), .rst_n(rst_n), .hint_valid(hint_valid), .hint_ready(hint_ready),
    .hint_pc(hint_pc), .hint_target(hint_target), .hint_type(hint_type),
    .hint_age(hint_age), .commit_cnt(commit_cnt), .release_win(release_win),
    .mon_threshold(mon_threshold), .resync(resync), .pred_pc(pred_pc),
    .pred_next(pred_next), .pred_from_hint(pred_from_hint),
    .res_valid(res_valid), .res_pc(res_pc), .res_next(res_next),
    .hints_enabled(hints_enabled), .hint_drops(hint_drops)
  );

  task automatic nb();
    @(negedge clk);
    hint_valid = 1'b0;
    res_valid  = 1'b0;
    resync     = 1'b0;
  endtask

  task automatic push_hint(input logic [31:0] pc, input logic [31:0] tgt,
                           input logic [1:0] kind, input logic [15:0] age);
    hint_valid = 1'b1; hint_pc = pc; hint_target = tgt;
    hint_type = kind; hint_age = age;
  endtask

  task automatic resolve(input logic [31:0] pc, input logic [31:0] nxt);
    res_valid = 1'b1; res_pc = pc; res_next = nxt;
  endtask

  task automatic expect_pred(input logic [31:0] pc, input logic [31:0] nxt,
                             input logic flag, input string tag);
    pred_pc = pc;
    exp_next_q.push_back(nxt);
    exp_flag_q.push_back(flag);
    exp_tag_q.push_back(tag);
  endtask

  task automatic check_status(input logic [7:0] exp_drops, input logic exp_en,
                              input string tag);
    #1;
    checks++;
    if (hint_drops !== exp_drops) begin
      errors++;
      $display("FAIL %s hint_drops actual %0d expected %0d", tag, hint_drops, exp_drops);
    end
    checks++;
    if (hints_enabled !== exp_en) begin
      errors++;
      $display("FAIL %s hints_enabled actual %0b expected %0b", tag, hints_enabled, exp_en);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #1;
    if (exp_next_q.size() > 0) begin
      logic [31:0] en;
      logic        ef;
      string       et;
      en = exp_next_q.pop_front();
      ef = exp_flag_q.pop_front();
      et = exp_tag_q.pop_front();
      checks++;
      if (pred_next !== en || pred_from_hint !== ef) begin
        errors++;
        $display("FAIL %s pred_next/flag actual %h/%0b expected %h/%0b",
                 et, pred_next, pred_from_hint, en, ef);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state, R1 ready
    nb(); expect_pred(32'h100, 32'h104, 1'b0, "R10 reset lookup");
    check_status(8'd0, 1'b1, "R10 reset status");
    checks++;
    if (hint_ready !== 1'b1) begin
      errors++; $display("FAIL R1 hint_ready actual %0b expected 1", hint_ready);
    end

    // R2 release gating, R3 stale drop
    nb(); push_hint(32'h100, 32'h200, 2'd0, 16'd20);
    nb(); expect_pred(32'h100, 32'h104, 1'b0, "R2 not yet released");
    nb(); commit_cnt = 16'd12; expect_pred(32'h100, 32'h200, 1'b1, "R2 released R4 sel reset");
    nb(); commit_cnt = 16'd21; expect_pred(32'h100, 32'h104, 1'b0, "R3 stale unused");
    nb(); commit_cnt = 16'd0;  expect_pred(32'h100, 32'h104, 1'b0, "R3 stale removed");

    // R9 consume, R5 native learn, R6 selection up
    nb(); push_hint(32'h100, 32'h200, 2'd0, 16'd1);
    nb(); expect_pred(32'h100, 32'h200, 1'b1, "R4 hint used");
    nb(); resolve(32'h100, 32'h200);
    nb(); expect_pred(32'h100, 32'h200, 1'b0, "R9 consumed R5 native taken");
    nb(); expect_pred(32'h104, 32'h108, 1'b0, "R5 untrained entry");

    // R6 selection moves toward native, R7 monitor disables hints
    nb(); push_hint(32'h100, 32'h300, 2'd0, 16'd1);
    nb(); expect_pred(32'h100, 32'h300, 1'b1, "R6 sel 3 picks hint");
    nb(); resolve(32'h100, 32'h200);
    nb(); push_hint(32'h100, 32'h300, 2'd0, 16'd1);
    nb(); expect_pred(32'h100, 32'h300, 1'b1, "R6 sel 2 picks hint");
    nb(); resolve(32'h100, 32'h200);
    nb(); push_hint(32'h100, 32'h300, 2'd0, 16'd1);
    nb(); expect_pred(32'h100, 32'h200, 1'b0, "R6 sel 1 picks native");
    check_status(8'd0, 1'b1, "R7 monitor at threshold");
    nb(); resolve(32'h100, 32'h200);
    nb(); check_status(8'd0, 1'b0, "R7 monitor above threshold");

    // R7 disabled uses native; R4 unconditional overrides selector
    nb(); push_hint(32'h100, 32'h400, 2'd1, 16'd1);
    nb(); expect_pred(32'h100, 32'h200, 1'b0, "R7 disabled native only");
    nb(); mon_threshold = 4'd5; expect_pred(32'h100, 32'h400, 1'b1, "R4 jump kind over sel 0");

    // R8 resync with concurrent hint
    nb(); resync = 1'b1; push_hint(32'h180, 32'h500, 2'd1, 16'd1);
    nb(); expect_pred(32'h100, 32'h200, 1'b0, "R8 flushed head");
    nb(); expect_pred(32'h180, 32'h200, 1'b0, "R8 concurrent hint discarded");
    check_status(8'd0, 1'b1, "R8 no drop counted");

    // R1 full buffer, drop counting, concurrent pop
    nb(); push_hint(32'h104, 32'h600, 2'd1, 16'd1);
    nb(); push_hint(32'h108, 32'h700, 2'd1, 16'd1);
    nb(); push_hint(32'h10c, 32'h800, 2'd1, 16'd1);
    nb(); push_hint(32'h110, 32'h900, 2'd1, 16'd1);
    nb(); push_hint(32'h120, 32'hB00, 2'd1, 16'd1);
    nb(); push_hint(32'h124, 32'hB00, 2'd1, 16'd1);
    nb(); check_status(8'd2, 1'b1, "R1 two drops at full");
    nb(); resolve(32'h104, 32'h600); push_hint(32'h130, 32'hB00, 2'd1, 16'd1);
    nb(); push_hint(32'h114, 32'hA00, 2'd1, 16'd1);
    nb(); expect_pred(32'h108, 32'h700, 1'b1, "R9 next head after consume");
    check_status(8'd3, 1'b1, "R1 drop while pop same cycle");
    nb(); resolve(32'h108, 32'h700);
    nb(); resolve(32'h10c, 32'h800);
    nb(); resolve(32'h110, 32'h900);
    nb(); expect_pred(32'h114, 32'hA00, 1'b1, "R1 hint accepted after slot freed");
    nb(); expect_pred(32'h130, 32'h134, 1'b0, "R1 discarded hint absent");

    nb(); nb(); nb();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule